// File: doc/BRIEF.md
# Two-Lane SIMD Status and Control Register

This block holds the 32-bit status and control word of a SIMD execution unit that works on a high lane and a low lane. The lane datapaths report their flags through three update ports. A full write replaces the word. A set-bits write ORs new bits into the current word. An overflow update sets or clears the overflow state of both lanes in a single operation. Every update passes through the same filter before it is stored. The filter zeroes the reserved positions and recomputes the sticky inexact and sticky divide-by-zero bits from the per-lane flags.

The stored word appears on `csr_o` in every cycle. A four-bit exception request is decoded combinationally from the stored word. A request bit is raised when a category flag is set in either lane and that category is enabled, either by its own enable or by the inexact enable. Trap delivery and processor-level gating sit outside this block.

Each lane owns an 8-bit field. Bit offsets within a lane field: 0 summary overflow, 1 overflow, 2 guard, 3 extra precision, 4 invalid, 5 divide-by-zero, 6 underflow, 7 overflow exception flag. The low lane sits at bits 7:0 and the high lane at bits 15:8.

Top module: `simd_stat_reg`

## Requirements
- R1: After an active-low asynchronous reset, `csr_o` is 0 and `exc_req_o` is 0.
- R2: Every stored value has bits 18, 19 and 25 through 29 forced to 0 (mask 0x3E0C0000). This covers full writes, set-bits writes and overflow updates.
- R3: The stored sticky inexact bit (bit 16) is 1 whenever the value being written has a guard or extra-precision flag set in either lane (bits 2, 3, 10, 11). Otherwise bit 16 takes the value carried in bit 16 of the value being written, so a full write with none of these flags and bit 16 clear clears it.
- R4: The stored sticky divide-by-zero bit (bit 17) is 1 whenever the value being written has the divide-by-zero flag of either lane set (bits 5, 13). Otherwise bit 17 takes the value carried in bit 17 of the value being written.
- R5: A set-bits write stores the filter result of (`csr_o` OR `set_bits_i`), so no stored bit is cleared by it.
- R6: An overflow update with `ov_lo_i`=1 sets bits 1 and 0. With `ov_lo_i`=0 it clears bit 1 and leaves bit 0 unchanged.
- R7: The same overflow update applies the rule of R6 to the high lane, using `ov_hi_i` with bits 9 and 8. Both lanes change in the same cycle.
- R8: `exc_req_o` bit k is 1 when lane flag offset 4+k is set in either lane and either enable bit 21+k or inexact enable bit 20 is set. The categories are k=0 invalid, 1 divide-by-zero, 2 underflow and 3 overflow. The request follows the stored word with no extra delay.
- R9: When updates coincide, a full write takes priority over set-bits, and set-bits takes priority over an overflow update. Only the winning update is applied.
- R10: The result of an update is visible on `csr_o` after the next rising clock edge. With no update asserted, the stored word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Full write strobe |
| wr_data_i | input | 32 | Full write value |
| set_en_i | input | 1 | Set-bits write strobe |
| set_bits_i | input | 32 | Bits to OR into the word |
| ov_upd_i | input | 1 | Overflow update strobe |
| ov_lo_i | input | 1 | Low lane overflowed |
| ov_hi_i | input | 1 | High lane overflowed |
| csr_o | output | 32 | Stored status word |
| exc_req_o | output | 4 | Exception request per category (invalid, dbz, underflow, overflow) |

## Verification
The hardest state to reach is one where a summary-overflow bit is set while its overflow bit is clear. Only a sequence of two overflow updates produces it: the first reports an overflow on a lane, and the second reports that the same lane did not overflow. The bench issues these two updates back to back with the lanes crossed. It then checks that the low summary bit survives while the low overflow bit clears, and that the high lane is set in the same step. Coinciding strobes are driven in a single cycle to expose the priority order.

// File: rtl/simd_stat_pkg.sv
package simd_stat_pkg;
  localparam int unsigned F_SUMOV = 0;
  localparam int unsigned F_OV    = 1;
  localparam int unsigned F_GUARD = 2;
  localparam int unsigned F_XPREC = 3;
  localparam int unsigned F_INV   = 4;
  localparam int unsigned F_DBZ   = 5;
  localparam int unsigned F_UNF   = 6;
  localparam int unsigned F_OVF   = 7;
  localparam int unsigned N_CAT   = 4;  // inv, dbz, unf, ovf at F_INV+k

  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_WR   = 2'd1,
    UPD_SET  = 2'd2,
    UPD_OV   = 2'd3
  } upd_sel_e;
endpackage

// File: rtl/simd_stat_filter.sv
module simd_stat_filter
  import simd_stat_pkg::*;
#(
  parameter int unsigned W         = 32,
  parameter int unsigned LO_BASE   = 0,
  parameter int unsigned HI_BASE   = 8,
  parameter int unsigned STK_INX   = 16,
  parameter int unsigned STK_DBZ   = 17,
  parameter logic [W-1:0] RSVD_MASK = 32'h3E0C_0000
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] filt_o
);
  logic inx_any, dbz_any;

  always_comb begin
    inx_any = raw_i[LO_BASE+F_GUARD] | raw_i[LO_BASE+F_XPREC] |
              raw_i[HI_BASE+F_GUARD] | raw_i[HI_BASE+F_XPREC];
    dbz_any = raw_i[LO_BASE+F_DBZ] | raw_i[HI_BASE+F_DBZ];
    filt_o  = raw_i & ~RSVD_MASK;
    if (inx_any) filt_o[STK_INX] = 1'b1;
    if (dbz_any) filt_o[STK_DBZ] = 1'b1;
  end
endmodule

// File: rtl/simd_stat_ovmerge.sv
module simd_stat_ovmerge
  import simd_stat_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned LO_BASE = 0,
  parameter int unsigned HI_BASE = 8
) (
  input  logic [W-1:0] cur_i,
  input  logic         ov_lo_i,
  input  logic         ov_hi_i,
  output logic [W-1:0] next_o
);
  localparam int unsigned NL = 2;
  logic [NL-1:0] ov_v;
  assign ov_v = {ov_hi_i, ov_lo_i};

  always_comb begin
    next_o = cur_i;
    for (int l = 0; l < NL; l++) begin
      // summary bit only ever set here, never cleared
      if (ov_v[l]) begin
        next_o[(l == 0 ? LO_BASE : HI_BASE) + F_OV]    = 1'b1;
        next_o[(l == 0 ? LO_BASE : HI_BASE) + F_SUMOV] = 1'b1;
      end else begin
        next_o[(l == 0 ? LO_BASE : HI_BASE) + F_OV]    = 1'b0;
      end
    end
  end
endmodule

// File: rtl/simd_stat_excreq.sv
module simd_stat_excreq
  import simd_stat_pkg::*;
(
  input  logic [N_CAT-1:0] lo_flag_i,
  input  logic [N_CAT-1:0] hi_flag_i,
  input  logic [N_CAT-1:0] cat_en_i,
  input  logic             inx_en_i,
  output logic [N_CAT-1:0] exc_o
);
  for (genvar k = 0; k < N_CAT; k++) begin : g_cat
    assign exc_o[k] = (lo_flag_i[k] | hi_flag_i[k]) & (cat_en_i[k] | inx_en_i);
  end
endmodule

// File: rtl/simd_stat_reg.sv
module simd_stat_reg
  import simd_stat_pkg::*;
#(
  parameter int unsigned W           = 32,
  parameter int unsigned LO_BASE     = 0,
  parameter int unsigned HI_BASE     = 8,
  parameter int unsigned STK_INX     = 16,
  parameter int unsigned STK_DBZ     = 17,
  parameter int unsigned EN_INX      = 20,
  parameter int unsigned EN_CAT_BASE = 21,
  parameter logic [W-1:0] RSVD_MASK  = 32'h3E0C_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             set_en_i,
  input  logic [W-1:0]     set_bits_i,
  input  logic             ov_upd_i,
  input  logic             ov_lo_i,
  input  logic             ov_hi_i,
  output logic [W-1:0]     csr_o,
  output logic [N_CAT-1:0] exc_req_o
);
  logic [W-1:0] csr_q, ov_raw, raw, filt;
  upd_sel_e     sel;

  simd_stat_ovmerge #(.W(W), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)) u_ov (
    .cur_i  (csr_q),
    .ov_lo_i(ov_lo_i),
    .ov_hi_i(ov_hi_i),
    .next_o (ov_raw)
  );

  always_comb begin
    if (wr_en_i)       sel = UPD_WR;
    else if (set_en_i) sel = UPD_SET;
    else if (ov_upd_i) sel = UPD_OV;
    else               sel = UPD_NONE;
    unique case (sel)
      UPD_WR:  raw = wr_data_i;
      UPD_SET: raw = csr_q | set_bits_i;
      UPD_OV:  raw = ov_raw;
      default: raw = csr_q;
    endcase
  end

  simd_stat_filter #(
    .W(W), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE),
    .STK_INX(STK_INX), .STK_DBZ(STK_DBZ), .RSVD_MASK(RSVD_MASK)
  ) u_filt (
    .raw_i (raw),
    .filt_o(filt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               csr_q <= '0;
    else if (sel != UPD_NONE)  csr_q <= filt;
  end

  assign csr_o = csr_q;

  logic [N_CAT-1:0] lo_flag, hi_flag, cat_en;
  for (genvar k = 0; k < N_CAT; k++) begin : g_slice
    assign lo_flag[k] = csr_q[LO_BASE + F_INV + k];
    assign hi_flag[k] = csr_q[HI_BASE + F_INV + k];
    assign cat_en[k]  = csr_q[EN_CAT_BASE + k];
  end

  simd_stat_excreq u_exc (
    .lo_flag_i(lo_flag),
    .hi_flag_i(hi_flag),
    .cat_en_i (cat_en),
    .inx_en_i (csr_q[EN_INX]),
    .exc_o    (exc_req_o)
  );

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_q & RSVD_MASK) == '0);  // R2
  AST_STICKY_INX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_q[LO_BASE+F_GUARD] | csr_q[LO_BASE+F_XPREC] |
     csr_q[HI_BASE+F_GUARD] | csr_q[HI_BASE+F_XPREC]) |-> csr_q[STK_INX]);  // R3
  AST_STICKY_DBZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_q[LO_BASE+F_DBZ] | csr_q[HI_BASE+F_DBZ]) |-> csr_q[STK_DBZ]);  // R4
  AST_SET_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i && !wr_en_i) |=> ((csr_q & $past(csr_q)) == $past(csr_q)));  // R5
  AST_OV_LO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_upd_i && !wr_en_i && !set_en_i && ov_lo_i)
      |=> (csr_q[LO_BASE+F_OV] && csr_q[LO_BASE+F_SUMOV]));  // R6
  AST_OV_LO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_upd_i && !wr_en_i && !set_en_i && !ov_lo_i)
      |=> (!csr_q[LO_BASE+F_OV] && $stable(csr_q[LO_BASE+F_SUMOV])));  // R6
  AST_OV_HI_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_upd_i && !wr_en_i && !set_en_i && ov_hi_i)
      |=> (csr_q[HI_BASE+F_OV] && csr_q[HI_BASE+F_SUMOV]));  // R7
  AST_EXC_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|exc_req_o) |-> (csr_q[EN_INX] | (|cat_en)));  // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !set_en_i && !ov_upd_i) |=> $stable(csr_q));  // R10
endmodule

// File: tb/tb_simd_stat_reg.sv
`timescale 1ns/1ps
module tb_simd_stat_reg;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, set_en_i = 1'b0, ov_upd_i = 1'b0;
  logic        ov_lo_i = 1'b0, ov_hi_i = 1'b0;
  logic [31:0] wr_data_i = '0, set_bits_i = '0;
  logic [31:0] csr_o;
  logic [3:0]  exc_req_o;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  simd_stat_reg dut (.*);

  // expected filter per R2-R4
  function automatic logic [31:0] flt(input logic [31:0] v);
    logic [31:0] r;
    r = v & ~32'h3E0C_0000;
    if (v[2] | v[3] | v[10] | v[11]) r[16] = 1'b1;
    if (v[5] | v[13]) r[17] = 1'b1;
    return r;
  endfunction

  function automatic logic [3:0] exc_of(input logic [31:0] c);
    logic [3:0] e;
    for (int k = 0; k < 4; k++) e[k] = (c[4+k] | c[12+k]) & (c[21+k] | c[20]);
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic do_set(input logic [31:0] d);
    @(negedge clk_i); set_en_i = 1'b1; set_bits_i = d;
    @(negedge clk_i); set_en_i = 1'b0;
  endtask

  task automatic do_ov(input logic lo, input logic hi);
    @(negedge clk_i); ov_upd_i = 1'b1; ov_lo_i = lo; ov_hi_i = hi;
    @(negedge clk_i); ov_upd_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 csr", csr_o, 32'h0);
    chk("R1 exc", {28'h0, exc_req_o}, 32'h0);
  endtask

  task automatic t_mask;
    do_wr(32'hFFFF_FFFF);
    chk("R2 full write", csr_o, 32'hC1F3_FFFF);
    do_wr(32'h0);
    do_set(32'h3000_0000);
    chk("R2 set write", csr_o, 32'h0);
  endtask

  task automatic t_sticky;
    do_wr(32'h0000_0004);
    chk("R3 lo guard", csr_o, 32'h0001_0004);
    do_wr(32'h0000_0800);
    chk("R3 hi xprec", csr_o, 32'h0001_0800);
    do_wr(32'h0);
    chk("R3 recompute clears", csr_o, 32'h0);
    do_wr(32'h0000_2000);
    chk("R4 hi dbz", csr_o, 32'h0002_2000);
    do_wr(32'h0000_0020);
    chk("R4 lo dbz", csr_o, flt(32'h0000_0020));
  endtask

  task automatic t_set;
    do_wr(32'h0000_0010);
    do_set(32'h0000_0020);
    chk("R5 or-in", csr_o, 32'h0002_0030);
    do_set(32'h8000_0000);
    chk("R5 keeps", csr_o, 32'h8002_0030);
  endtask

  task automatic t_ov;
    do_wr(32'h0);
    do_ov(1'b1, 1'b0);
    chk("R6 lo set", csr_o, 32'h0000_0003);
    do_ov(1'b0, 1'b1);
    chk("R6 R7 lo clr hi set", csr_o, 32'h0000_0301);
    do_ov(1'b0, 1'b0);
    chk("R7 hi clr keeps sum", csr_o, 32'h0000_0101);
  endtask

  task automatic t_exc;
    logic [31:0] v[5] = '{32'h0020_0010, 32'h0010_0010, 32'h0000_2000,
                          32'h0100_0080, 32'h0010_4000};
    logic [3:0]  e[5] = '{4'b0001, 4'b0001, 4'b0000, 4'b1000, 4'b0100};
    for (int i = 0; i < 5; i++) begin
      do_wr(v[i]);
      chk("R8 exc", {28'h0, exc_req_o}, {28'h0, e[i]});
      chk("R8 model", {28'h0, exc_req_o}, {28'h0, exc_of(flt(v[i]))});
    end
  endtask

  task automatic t_prio;
    do_wr(32'h0);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = 32'h4000_0000;
    set_en_i = 1'b1; set_bits_i = 32'h0000_0001;
    ov_upd_i = 1'b1; ov_lo_i = 1'b1; ov_hi_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R9 write wins", csr_o, 32'h4000_0000);
    chk("R10 one edge", csr_o, 32'h4000_0000);
    @(negedge clk_i);  // set and ov still asserted: set wins
    set_en_i = 1'b0; ov_upd_i = 1'b0;
    chk("R9 set over ov", csr_o, 32'h4000_0001);
    @(negedge clk_i);
    chk("R10 hold", csr_o, 32'h4000_0001);
  endtask

  initial begin
    #1 chk("R1 async reset", csr_o, 32'h0);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_mask();
    t_sticky();
    t_set();
    t_ov();
    t_exc();
    t_prio();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule